// File: doc/BRIEF.md
# Debug Breakpoint Status Unit

This block holds four debug breakpoint slots, each with an address register. A shared control register selects, per slot, whether the slot is enabled and what kind of event it watches. When the core asks for a check, the unit compares every slot against the current instruction pointer, or against an external watch-hit flag. It then forms the next value of a debug status register and raises a debug-exception request if any enabled slot matched.

The memory-watch comparison itself happens outside this block. It arrives here as one hit flag per slot. Status bits are recorded for every matching slot, including disabled ones. However, the status register only takes the new value when an enabled slot matched or the caller forces the update. The caller uses a forced update to refresh the status after a software breakpoint trap. The address, status and control registers are loaded through a single write port.

Top module: `brk_status_unit`

## Requirements
- R1: After reset, all four address registers read 0, the status register reads 0xFFFF0FF0, the control register reads 0x00000400, and excReq is low.
- R2: On a clock edge with wrEn high, wrSel 0 to 3 loads address slot wrSel, wrSel 4 loads the status register and wrSel 5 loads the control register. The status write stores wrData OR 0xFFFF0FF0. The control write stores wrData OR 0x00000400. wrSel 6 and 7 change no register.
- R3: A slot whose 2-bit type field is 0 matches when its address register equals instPtr. For slot i the type field is control bits [17+4i:16+4i].
- R4: A slot of type 1 or type 3 matches when its watchHit bit is high, regardless of instPtr.
- R5: A slot of type 2 never matches, even when its address equals instPtr or its watchHit bit is high.
- R6: Slot i is enabled when control bit 2i or control bit 2i+1 is set.
- R7: A committed check writes the current status with bits [3:0] replaced by the match vector of all matching slots, enabled or not. Bit i of the vector is slot i. Bits [31:4] are kept.
- R8: A check with checkReq high commits only if some enabled slot matches or forceUpd is high. Otherwise the status register is unchanged, and without checkReq nothing commits.
- R9: excReq is combinational. It is high exactly when checkReq is high and at least one enabled slot matches. forceUpd does not affect it.
- R10: When a status write and a committing check fall on the same edge, the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instPtr | input | 32 | Current instruction pointer |
| watchHit | input | 4 | Per-slot external watch-hit flags |
| checkReq | input | 1 | Evaluate the slots this cycle |
| forceUpd | input | 1 | Commit the status even without an enabled match |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 3 | Write target: 0-3 address slot, 4 status, 5 control |
| wrData | input | 32 | Write data |
| rdSel | input | 2 | Address slot shown on addrRd |
| addrRd | output | 32 | Selected address register |
| statusOut | output | 32 | Debug status register |
| ctrlOut | output | 32 | Debug control register |
| excReq | output | 1 | Debug-exception request |

## Verification
The check function is exercised with several kinds of input:
- an enabled execution match alone, which separates the address compare from the watch path;
- a disabled slot matching with and without forceUpd, which separates recording a match from committing it;
- an enabled and a disabled match together, which shows that both status bits appear while only the enabled one raises the request;
- a type-2 slot given both an address match and a watch flag, and a write-type slot given only an address match, which show that the type decode gates the right source;
- a check with checkReq low and one that coincides with a status write, which pin down commit timing and priority.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NSLOT = 4;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    BK_EXEC  = 2'd0,
    BK_WRITE = 2'd1,
    BK_IO    = 2'd2,
    BK_RDWR  = 2'd3
  } bkType_e;

  // Write-select codes
  localparam logic [2:0] SEL_STATUS = 3'd4;
  localparam logic [2:0] SEL_CTRL   = 3'd5;

  localparam logic [31:0] STAT_FIXED = 32'hFFFF_0FF0;
  localparam logic [31:0] CTRL_FIXED = 32'h0000_0400;

  // Strobes from the match control to the register datapath
  typedef struct packed {
    logic             commit;
    logic [NSLOT-1:0] hitBits;
  } stsStrobe_t;
endpackage

// File: rtl/brk_match_ctrl.sv
module brk_match_ctrl
  import brk_pkg::*;
#(
  parameter int SLOTS = NSLOT,
  parameter int WIDTH = XLEN
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        checkReq,
  input  logic                        forceUpd,
  input  logic [WIDTH-1:0]            instPtr,
  input  logic [SLOTS-1:0]            watchHit,
  input  logic [WIDTH-1:0]            ctrlReg,
  input  logic [SLOTS-1:0][WIDTH-1:0] slotAddr,
  output stsStrobe_t                  strobe,
  output logic                        excReq
);
  // Enable pairs sit at the bottom, the type/length nibbles start above them
  localparam int ENA_BITS = 2 * SLOTS;
  localparam int TYPE_LSB = ENA_BITS + 8;

  logic [SLOTS-1:0] hitVec;
  logic [SLOTS-1:0] enVec;
  logic             anyEnHit;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      bkType_e slotType;
      logic    addrEq;
      assign slotType = bkType_e'(ctrlReg[TYPE_LSB + 4*i +: 2]);
      assign enVec[i] = |ctrlReg[2*i +: 2];
      assign addrEq   = (slotAddr[i] == instPtr);
      always_comb begin
        unique case (slotType)
          BK_EXEC:          hitVec[i] = addrEq;
          BK_WRITE, BK_RDWR: hitVec[i] = watchHit[i];
          default:          hitVec[i] = 1'b0;
        endcase
      end

      // R5: an I/O-type slot must never report a match
      p_io_nohit_r5: assert property (@(posedge clk) disable iff (!rstN)
        (slotType == BK_IO) |-> !hitVec[i]);
    end
  endgenerate

  logic unusedCtrlBits;
  assign unusedCtrlBits = ^ctrlReg;

  assign anyEnHit       = |(hitVec & enVec);
  assign excReq         = checkReq & anyEnHit;
  assign strobe.commit  = checkReq & (anyEnHit | forceUpd);
  assign strobe.hitBits = hitVec;

  // R9: a request always comes with a commit, never without a check
  p_exc_commits_r9: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> strobe.commit);
  p_exc_needs_check_r9: assert property (@(posedge clk) disable iff (!rstN)
    !checkReq |-> !excReq);
  // R8: no commit unless a check is requested
  p_commit_check_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> checkReq);
endmodule

// File: rtl/brk_reg_datapath.sv
module brk_reg_datapath
  import brk_pkg::*;
#(
  parameter int SLOTS = NSLOT,
  parameter int WIDTH = XLEN
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [2:0]                  wrSel,
  input  logic [WIDTH-1:0]            wrData,
  input  logic [$clog2(SLOTS)-1:0]    rdSel,
  input  stsStrobe_t                  strobe,
  output logic [SLOTS-1:0][WIDTH-1:0] slotAddr,
  output logic [WIDTH-1:0]            statusReg,
  output logic [WIDTH-1:0]            ctrlReg,
  output logic [WIDTH-1:0]            addrRd
);
  localparam logic [WIDTH-1:0] LOW_MASK  = {{(WIDTH-SLOTS){1'b0}}, {SLOTS{1'b1}}};
  localparam logic [WIDTH-1:0] STAT_ONES = WIDTH'(STAT_FIXED);
  localparam logic [WIDTH-1:0] CTRL_ONES = WIDTH'(CTRL_FIXED);

  logic statusWr;
  logic ctrlWr;
  assign statusWr = wrEn && (wrSel == SEL_STATUS);
  assign ctrlWr   = wrEn && (wrSel == SEL_CTRL);

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_addr
      always_ff @(posedge clk) begin
        if (!rstN)
          slotAddr[i] <= '0;
        else if (wrEn && (wrSel == 3'(i)))
          slotAddr[i] <= wrData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)
      statusReg <= STAT_ONES;
    else if (statusWr)
      statusReg <= wrData | STAT_ONES;
    else if (strobe.commit)
      statusReg <= (statusReg & ~LOW_MASK) | WIDTH'(strobe.hitBits);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      ctrlReg <= CTRL_ONES;
    else if (ctrlWr)
      ctrlReg <= wrData | CTRL_ONES;
  end

  assign addrRd = slotAddr[rdSel];

  // R2: fixed-one bits stay set in both registers
  p_fixed_ones_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((statusReg & STAT_ONES) == STAT_ONES) && ((ctrlReg & CTRL_ONES) == CTRL_ONES));
  // R7: a committed check leaves the match vector in the low bits
  p_commit_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && !statusWr) |=> (statusReg[SLOTS-1:0] == $past(strobe.hitBits)));
  // R8: without commit or write the status holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.commit && !statusWr) |=> $stable(statusReg));
  // R10: a status write wins over a commit
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    statusWr |=> (statusReg == ($past(wrData) | STAT_ONES)));
endmodule

// File: rtl/brk_status_unit.sv
module brk_status_unit
  import brk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] instPtr,
  input  logic [3:0]  watchHit,
  input  logic        checkReq,
  input  logic        forceUpd,
  input  logic        wrEn,
  input  logic [2:0]  wrSel,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdSel,
  output logic [31:0] addrRd,
  output logic [31:0] statusOut,
  output logic [31:0] ctrlOut,
  output logic        excReq
);
  stsStrobe_t                  strobe;
  logic [NSLOT-1:0][XLEN-1:0]  slotAddr;

  brk_match_ctrl #(.SLOTS(NSLOT), .WIDTH(XLEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .checkReq (checkReq),
    .forceUpd (forceUpd),
    .instPtr  (instPtr),
    .watchHit (watchHit),
    .ctrlReg  (ctrlOut),
    .slotAddr (slotAddr),
    .strobe   (strobe),
    .excReq   (excReq)
  );

  brk_reg_datapath #(.SLOTS(NSLOT), .WIDTH(XLEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .rdSel     (rdSel),
    .strobe    (strobe),
    .slotAddr  (slotAddr),
    .statusReg (statusOut),
    .ctrlReg   (ctrlOut),
    .addrRd    (addrRd)
  );
endmodule

// File: tb/tb_brk_status_unit.sv
module tb_brk_status_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instPtr = '0;
  logic [3:0]  watchHit = '0;
  logic        checkReq = 1'b0;
  logic        forceUpd = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdSel = '0;
  logic [31:0] addrRd, statusOut, ctrlOut;
  logic        excReq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  brk_status_unit dut (.*);

  task automatic doCheck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readAddr(input int slot, input logic [31:0] exp, input string tag);
    rdSel = 2'(slot);
    #1 doCheck(tag, addrRd, exp);
  endtask

  // One check cycle: excReq checked before the edge, status after it
  task automatic runCheck(input logic [31:0] ip, input logic [3:0] wh, input logic frc,
                          input logic expExc, input logic [31:0] expStat, input string tag);
    @(negedge clk);
    instPtr = ip; watchHit = wh; forceUpd = frc; checkReq = 1'b1;
    #1 doCheck({tag, " excReq"}, 32'(excReq), 32'(expExc));
    @(negedge clk);
    checkReq = 1'b0; forceUpd = 1'b0; watchHit = '0;
    #1 doCheck({tag, " status"}, statusOut, expStat);
  endtask

  task automatic testReset();
    doCheck("R1 status", statusOut, 32'hFFFF0FF0);
    doCheck("R1 ctrl", ctrlOut, 32'h00000400);
    doCheck("R1 excReq", 32'(excReq), 32'h0);
    for (int i = 0; i < 4; i++) readAddr(i, 32'h0, "R1 addr");
  endtask

  task automatic testWrites();
    regWrite(3'd0, 32'h1000); regWrite(3'd1, 32'h2000);
    regWrite(3'd2, 32'h3000); regWrite(3'd3, 32'h4000);
    for (int i = 0; i < 4; i++) readAddr(i, 32'h1000 * (i + 1), "R2 addr write");
    regWrite(3'd4, 32'h0);
    doCheck("R2 status fixed ones", statusOut, 32'hFFFF0FF0);
    regWrite(3'd5, 32'h0);
    doCheck("R2 ctrl fixed ones", ctrlOut, 32'h00000400);
    regWrite(3'd6, 32'hDEADBEEF);
    regWrite(3'd7, 32'h12345678);
    doCheck("R2 sel6/7 status", statusOut, 32'hFFFF0FF0);
    doCheck("R2 sel6/7 ctrl", ctrlOut, 32'h00000400);
    for (int i = 0; i < 4; i++) readAddr(i, 32'h1000 * (i + 1), "R2 sel6/7 addr");
  endtask

  task automatic testExecHit();
    regWrite(3'd5, 32'h1);  // slot0 enabled, type exec
    runCheck(32'h1000, 4'h0, 1'b0, 1'b1, 32'hFFFF0FF1, "R3 exec enabled hit");
    runCheck(32'h1004, 4'h0, 1'b0, 1'b0, 32'hFFFF0FF1, "R3 exec miss");
  endtask

  task automatic testDisabled();
    // slot1 type exec but disabled: no commit without force
    runCheck(32'h2000, 4'h0, 1'b0, 1'b0, 32'hFFFF0FF1, "R8 disabled no force");
    runCheck(32'h2000, 4'h0, 1'b1, 1'b0, 32'hFFFF0FF2, "R7 disabled forced");
    // slot1 write type disabled plus enabled slot0 exec
    regWrite(3'd5, 32'h0010_0001);
    runCheck(32'h1000, 4'h2, 1'b0, 1'b1, 32'hFFFF0FF3, "R7 mixed hits");
  endtask

  task automatic testTypes();
    regWrite(3'd4, 32'h0);
    // slot2 type IO enabled (bit4)
    regWrite(3'd5, 32'h0200_0010);
    runCheck(32'h3000, 4'h4, 1'b1, 1'b0, 32'hFFFF0FF0, "R5 io never hits");
    // slot3 type rd/wr enabled by upper enable bit 7
    regWrite(3'd5, 32'h3000_0080);
    runCheck(32'h0, 4'h8, 1'b0, 1'b1, 32'hFFFF0FF8, "R4 R6 rdwr hit");
    // slot1 write type enabled by bit2: address match alone is no hit
    regWrite(3'd5, 32'h0010_0004);
    runCheck(32'h2000, 4'h0, 1'b1, 1'b0, 32'hFFFF0FF0, "R4 write ignores address");
    runCheck(32'h9999, 4'h2, 1'b0, 1'b1, 32'hFFFF0FF2, "R6 write hit enabled");
  endtask

  task automatic testNoCheck();
    @(negedge clk);
    watchHit = 4'h2; instPtr = 32'h2000;
    #1 doCheck("R9 no checkReq excReq", 32'(excReq), 32'h0);
    @(negedge clk);
    watchHit = '0;
    #1 doCheck("R8 no checkReq status", statusOut, 32'hFFFF0FF2);
  endtask

  task automatic testPriority();
    @(negedge clk);
    watchHit = 4'h2; checkReq = 1'b1;
    wrEn = 1'b1; wrSel = 3'd4; wrData = 32'h0000_8000;
    @(negedge clk);
    watchHit = '0; checkReq = 1'b0; wrEn = 1'b0;
    #1 doCheck("R10 write over commit", statusOut, 32'hFFFF8FF0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 testReset();
    testWrites();
    testExecHit();
    testDisabled();
    testTypes();
    testNoCheck();
    testPriority();
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule